// File: doc/BRIEF.md
# Front-End Configuration Serial Bridge

This block links a fast command clock to a group of front-end chips whose configuration port runs at one eighth of that rate. The block makes the slow front-end clock itself, as a divide-by-eight phase count gated onto an output pin. It works in one of two directions for each transfer. The mode, the two length counts and the input-enable mask are given with a one-cycle start pulse.

In write mode a source supplies a serial bit stream over a valid/ready handshake. The bridge holds each bit on the front-end data pin for eight fast cycles. A load pin stays low while the control part of the stream goes out and high while the data part goes out. On back-pressure, `wr_ready` is high only in a cycle where the bridge can take the next bit, and a bit moves only in a cycle where `wr_valid` and `wr_ready` are both high. While the source withholds a bit, the bridge holds the current bit and stops the front-end clock. No bit is lost or repeated. When the source keeps valid high, the bits go out back to back with no gap.

In readback mode the bridge sends a fixed five-bit header at one fast cycle per bit. It then sends the front-end answer. That answer is the OR of the enabled front-end inputs, sampled on each rising edge of the front-end clock and held for eight fast cycles. The same stream goes out on two output lanes, and the output sink has no back-pressure. A `busy` flag covers each transfer, and a one-cycle `done` pulse follows the last bit.

Top module: `fe_cfg_bridge`

## Requirements
- R1: In write mode each accepted bit appears on `fe_dout` in the cycle after its acceptance and stays there for 8 cycles. When `wr_valid` stays high, bit k is accepted in cycle 1+8k, counting the cycle after the start edge as cycle 1.
- R2: A write transfer carries exactly `ctrl_cnt`×8 + `data_cnt` bits. They go out in the order they were accepted, and each bit is on `fe_dout` at the rising edge of `fe_sclk` that belongs to it.
- R3: `fe_load` is 0 for the first `ctrl_cnt`×8 bits of a write transfer and 1 for the remaining `data_cnt` bits.
- R4: A readback transfer starts in the cycle after the start edge with the header 1,1,1,0,1, one bit per cycle, in that order.
- R5: After the header, a readback sends `data_cnt` bits, each held 8 cycles. Bit k is the OR over i of `fe_din[i] & fe_enable[i]`, sampled at the k-th rising edge of `fe_sclk` (the edge that ends cycle 8k+5), and it appears from cycle 8k+6.
- R6: An input whose `fe_enable` bit is 0 has no effect on the readback data; with a zero mask every data bit is 0.
- R7: `rb_lane0` and `rb_lane1` are always equal. `rb_valid` is high exactly while a readback is sending, and both lanes are 0 whenever `rb_valid` is low.
- R8: `wr_ready` is high only during a write transfer while the bridge waits for its next bit. A cycle with `wr_ready` high and `wr_valid` low accepts nothing, and the current bit stays on `fe_dout` with no `fe_sclk` rising edge until a bit is accepted.
- R9: `busy` is high from the cycle after an accepted start to the last cycle of the last bit, and `done` is high for the single following cycle. A start while `busy` is high is ignored.
- R10: A write with `ctrl_cnt` and `data_cnt` both zero sends nothing, never raises `busy`, and pulses `done` in the cycle after the start.
- R11: `fe_sclk` is 0 whenever `busy` is 0. Inside each 8-cycle bit slot it is high for the last 3 cycles, so a transfer of n slow bits shows exactly n rising edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast command clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | One-cycle request to begin a transfer |
| mode | input | 1 | 0 = write to front ends, 1 = readback |
| ctrl_cnt | input | 3 | Control length in units of 8 bits (write only) |
| data_cnt | input | 13 | Data length in bits |
| fe_enable | input | 16 | Bit i enables front-end input i for readback |
| wr_valid | input | 1 | Write stream: bit offered |
| wr_bit | input | 1 | Write stream: bit value |
| wr_ready | output | 1 | Write stream: bridge takes a bit this cycle |
| fe_sclk | output | 1 | Slow front-end clock (fast clock / 8) |
| fe_dout | output | 1 | Serial configuration data to the front ends |
| fe_load | output | 1 | Low for control bits, high for data bits |
| fe_din | input | 16 | Serial answers from the front ends |
| rb_valid | output | 1 | Readback stream being sent |
| rb_lane0 | output | 1 | Readback serial output, lane 0 |
| rb_lane1 | output | 1 | Readback serial output, lane 1 |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse after the last bit |

## Verification
The hardest case to reach is a withheld bit at the exact slot boundary. That is the eighth cycle of a held bit, where the bridge offers `wr_ready` while the current bit is still on the pin. The bench reaches it by gating `wr_valid` with a cycle-number pattern that often lands on that boundary and sometimes lands inside a wait state. It then checks that every bit still sits on `fe_dout` for 8 cycles and that the count of clock edges stays exact. For readback, `fe_din` changes every cycle. Only the value present at each sampling edge may reach the lanes, so a sampling phase that is off by one cycle shows up as a data mismatch.

// File: rtl/fecfg_pkg.sv
package fecfg_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_WFETCH = 2'd1,
    ST_WSHIFT = 2'd2,
    ST_RSEND  = 2'd3
  } fecfg_state_e;

  localparam logic     MODE_READBACK = 1'b1;
  localparam int       RB_HDR_LEN    = 5;
  localparam logic [RB_HDR_LEN-1:0] RB_HEADER = 5'b11101;
  localparam int       NUM_LANES     = 2;

endpackage

// File: rtl/fecfg_phase.sv
module fecfg_phase #(
  parameter int SLOT      = 8,
  parameter int HIGH_FROM = 5,
  localparam int PH_W     = $clog2(SLOT)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            adv,
  output logic [PH_W-1:0] ph,
  output logic            ph_last,
  output logic            ph_high
);

  logic [PH_W-1:0] ph_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph_q <= '0;
    end else if (clr) begin
      ph_q <= '0;
    end else if (adv) begin
      ph_q <= (ph_q == PH_W'(SLOT - 1)) ? '0 : ph_q + PH_W'(1);
    end
  end

  assign ph      = ph_q;
  assign ph_last = (ph_q == PH_W'(SLOT - 1));
  assign ph_high = (ph_q >= PH_W'(HIGH_FROM));

endmodule

// File: rtl/fecfg_fe_merge.sv
module fecfg_fe_merge #(
  parameter int NUM_FE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_mask,
  input  logic [NUM_FE-1:0] mask_in,
  input  logic              sample_en,
  input  logic [NUM_FE-1:0] fe_din,
  output logic              sampled
);

  logic [NUM_FE-1:0] mask_q;
  logic [NUM_FE-1:0] gated;
  logic              smp_q;

  for (genvar gi = 0; gi < NUM_FE; gi++) begin : g_gate
    assign gated[gi] = fe_din[gi] & mask_q[gi];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q <= '0;
      smp_q  <= 1'b0;
    end else if (load_mask) begin
      mask_q <= mask_in;
      smp_q  <= 1'b0;
    end else if (sample_en) begin
      smp_q  <= |gated;
    end
  end

  assign sampled = smp_q;

  AST_MASKED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_en && !load_mask && (mask_q == '0)) |=> !sampled); // R6

endmodule

// File: rtl/fecfg_lane_drv.sv
module fecfg_lane_drv #(
  parameter int                      SLOT     = 8,
  parameter int                      HDR_LEN  = 5,
  parameter logic [HDR_LEN-1:0]      HDR      = 5'b11101,
  parameter int                      LANES    = 2,
  localparam int                     PH_W     = $clog2(SLOT),
  localparam int                     PH_SPAN  = 1 << PH_W
) (
  input  logic             active,
  input  logic             hdr_phase,
  input  logic [PH_W-1:0]  ph,
  input  logic             data_bit,
  output logic [LANES-1:0] lanes
);

  logic [PH_SPAN-1:0] hdr_by_ph;
  logic               lane_bit;

  for (genvar gp = 0; gp < PH_SPAN; gp++) begin : g_hdr
    if (gp < HDR_LEN) begin : g_in
      assign hdr_by_ph[gp] = HDR[HDR_LEN-1-gp];
    end else begin : g_pad
      assign hdr_by_ph[gp] = 1'b0;
    end
  end

  assign lane_bit = active & (hdr_phase ? hdr_by_ph[ph] : data_bit);

  for (genvar gl = 0; gl < LANES; gl++) begin : g_lane
    assign lanes[gl] = lane_bit;
  end

endmodule

// File: rtl/fe_cfg_bridge.sv
module fe_cfg_bridge
  import fecfg_pkg::*;
#(
  parameter int NUM_FE = 16,
  parameter int CTRL_W = 3,
  parameter int DATA_W = 13,
  parameter int SLOT   = 8,
  localparam int PH_W   = $clog2(SLOT),
  localparam int CB_W   = CTRL_W + PH_W,
  localparam int CNT_W  = ((DATA_W > CB_W) ? DATA_W : CB_W) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              mode,
  input  logic [CTRL_W-1:0] ctrl_cnt,
  input  logic [DATA_W-1:0] data_cnt,
  input  logic [NUM_FE-1:0] fe_enable,
  input  logic              wr_valid,
  input  logic              wr_bit,
  output logic              wr_ready,
  output logic              fe_sclk,
  output logic              fe_dout,
  output logic              fe_load,
  input  logic [NUM_FE-1:0] fe_din,
  output logic              rb_valid,
  output logic              rb_lane0,
  output logic              rb_lane1,
  output logic              busy,
  output logic              done
);

  fecfg_state_e    state_q;
  logic [CNT_W-1:0] idx_q, tot_q, ctrl_bits_q, slot_q;
  logic             dout_q, load_q, done_q;

  logic [PH_W-1:0]  ph;
  logic             ph_last, ph_high, ph_clr, ph_adv;
  logic             start_ok, accept, idx_last, at_sample_ph;
  logic             wr_active, sample_en, hdr_phase, sampled;
  logic [CNT_W-1:0] wr_ctrl_bits, wr_total, idx_inc;
  logic [NUM_LANES-1:0] lanes;

  assign start_ok     = start && (state_q == ST_IDLE);
  assign wr_ctrl_bits = CNT_W'(ctrl_cnt) * CNT_W'(SLOT);
  assign wr_total     = wr_ctrl_bits + CNT_W'(data_cnt);
  assign idx_inc      = idx_q + CNT_W'(1);
  assign idx_last     = (idx_q == tot_q - CNT_W'(1));
  assign at_sample_ph = (ph == PH_W'(RB_HDR_LEN - 1));
  assign wr_active    = (state_q == ST_WFETCH) || (state_q == ST_WSHIFT);

  assign wr_ready = (state_q == ST_WFETCH) ||
                    ((state_q == ST_WSHIFT) && ph_last && !idx_last);
  assign accept   = wr_ready && wr_valid;

  assign ph_clr = accept || (start_ok && (mode == MODE_READBACK));
  assign ph_adv = (state_q == ST_WSHIFT) || (state_q == ST_RSEND);

  assign sample_en = (state_q == ST_RSEND) && at_sample_ph && (slot_q != tot_q);
  assign hdr_phase = (slot_q == '0) && (ph < PH_W'(RB_HDR_LEN));

  fecfg_phase #(.SLOT(SLOT), .HIGH_FROM(RB_HDR_LEN)) u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (ph_clr),
    .adv     (ph_adv),
    .ph      (ph),
    .ph_last (ph_last),
    .ph_high (ph_high)
  );

  fecfg_fe_merge #(.NUM_FE(NUM_FE)) u_merge (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_mask (start_ok),
    .mask_in   (fe_enable),
    .sample_en (sample_en),
    .fe_din    (fe_din),
    .sampled   (sampled)
  );

  fecfg_lane_drv #(
    .SLOT    (SLOT),
    .HDR_LEN (RB_HDR_LEN),
    .HDR     (RB_HEADER),
    .LANES   (NUM_LANES)
  ) u_lanes (
    .active    (state_q == ST_RSEND),
    .hdr_phase (hdr_phase),
    .ph        (ph),
    .data_bit  (sampled),
    .lanes     (lanes)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      idx_q       <= '0;
      tot_q       <= '0;
      ctrl_bits_q <= '0;
      slot_q      <= '0;
      dout_q      <= 1'b0;
      load_q      <= 1'b0;
      done_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            dout_q <= 1'b0;
            load_q <= 1'b0;
            idx_q  <= '0;
            slot_q <= '0;
            if (mode == MODE_READBACK) begin
              tot_q   <= CNT_W'(data_cnt);
              state_q <= ST_RSEND;
            end else begin
              tot_q       <= wr_total;
              ctrl_bits_q <= wr_ctrl_bits;
              if (wr_total == '0) done_q  <= 1'b1;
              else                state_q <= ST_WFETCH;
            end
          end
        end
        ST_WFETCH: begin
          if (wr_valid) begin
            dout_q  <= wr_bit;
            load_q  <= (idx_q >= ctrl_bits_q);
            state_q <= ST_WSHIFT;
          end
        end
        ST_WSHIFT: begin
          if (ph_last) begin
            if (idx_last) begin
              state_q <= ST_IDLE;
              done_q  <= 1'b1;
            end else begin
              idx_q <= idx_inc;
              if (wr_valid) begin
                dout_q <= wr_bit;
                load_q <= (idx_inc >= ctrl_bits_q);
              end else begin
                state_q <= ST_WFETCH;
              end
            end
          end
        end
        ST_RSEND: begin
          if (ph_last) slot_q <= slot_q + CNT_W'(1);
          if (at_sample_ph && (slot_q == tot_q)) begin
            state_q <= ST_IDLE;
            done_q  <= 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign fe_dout  = dout_q & wr_active;
  assign fe_load  = load_q & wr_active;
  assign fe_sclk  = ph_adv & ph_high;
  assign rb_valid = (state_q == ST_RSEND);
  assign rb_lane0 = lanes[0];
  assign rb_lane1 = lanes[NUM_LANES-1];
  assign busy     = (state_q != ST_IDLE);
  assign done     = done_q;

  AST_BIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_WSHIFT) && ($past(state_q) == ST_WSHIFT) && !$past(accept))
      |-> ($stable(fe_dout) && $stable(fe_load))); // R1

  AST_LOAD_NO_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(wr_active) && wr_active && $past(fe_load)) |-> fe_load); // R3

  AST_HDR_LEADS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rb_valid) |-> rb_lane0); // R4

  AST_LANES_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !rb_valid |-> (!rb_lane0 && !rb_lane1)); // R7

  AST_READY_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready |-> (busy && !rb_valid)); // R8

  AST_DONE_ON_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done); // R9

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !fe_sclk); // R11

endmodule

// File: tb/fe_cfg_bridge_test.sv
`timescale 1ns/1ps
module fe_cfg_bridge_test;

  logic        clk = 1'b0;
  logic        rst_n, start, mode, wr_valid, wr_bit;
  logic [2:0]  ctrl_cnt;
  logic [12:0] data_cnt;
  logic [15:0] fe_enable, fe_din;
  logic        wr_ready, fe_sclk, fe_dout, fe_load;
  logic        rb_valid, rb_lane0, rb_lane1, busy, done;

  always #4 clk = ~clk;

  fe_cfg_bridge uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
    .ctrl_cnt(ctrl_cnt), .data_cnt(data_cnt), .fe_enable(fe_enable),
    .wr_valid(wr_valid), .wr_bit(wr_bit), .wr_ready(wr_ready),
    .fe_sclk(fe_sclk), .fe_dout(fe_dout), .fe_load(fe_load),
    .fe_din(fe_din), .rb_valid(rb_valid), .rb_lane0(rb_lane0),
    .rb_lane1(rb_lane1), .busy(busy), .done(done)
  );

  int checks = 0;
  int fails  = 0;
  int wd     = 0;
  logic [15:0] lfsr = 16'hACE1;

  logic        r_dout [2048];
  logic        r_load [2048];
  logic        r_l0   [2048];
  logic        r_l1   [2048];
  logic        r_rbv  [2048];
  logic [15:0] r_din  [2048];
  logic        wb     [1024];
  int          acc    [1024];
  logic        rs_val [1024];
  logic        rs_ld  [1024];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step_lfsr();
    lfsr = lfsr ^ (lfsr << 7);
    lfsr = lfsr ^ (lfsr >> 9);
    lfsr = lfsr ^ (lfsr << 8);
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", wd, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic run_write(input int c, input int d, input bit stall);
    int   tot    = c * 8 + d;
    int   nxt    = 0;
    int   rises  = 0;
    int   busy_n = 0;
    int   hi_n   = 0;
    int   extra  = 0;
    int   done_c = -1;
    logic prev   = 1'b0;
    for (int k = 0; k < tot; k++) begin
      step_lfsr();
      wb[k] = lfsr[0];
    end
    @(negedge clk);
    mode = 1'b0; ctrl_cnt = 3'(c); data_cnt = 13'(d); start = 1'b1; wr_valid = 1'b0;
    for (int cy = 1; cy < 1500; cy++) begin
      @(negedge clk);
      start = 1'b0;
      if (busy) busy_n++;
      if (fe_sclk) hi_n++;
      if (fe_sclk && !prev && rises < 1024) begin
        rs_val[rises] = fe_dout;
        rs_ld[rises]  = fe_load;
        rises++;
      end
      prev = fe_sclk;
      r_dout[cy] = fe_dout;
      r_load[cy] = fe_load;
      if (done) begin
        done_c = cy;
        chk(!wr_ready && !busy, "R8 no ready after end", int'(wr_ready), 0);
        wr_valid = 1'b0;
        break;
      end
      if (wr_ready && nxt >= tot) extra++;
      if (wr_ready && nxt < tot && !(stall && (cy % 5 == 2))) begin
        wr_valid = 1'b1; wr_bit = wb[nxt]; acc[nxt] = cy; nxt++;
      end else begin
        wr_valid = 1'b0; wr_bit = 1'b0;
      end
    end
    chk(done_c > 0, "R9 done pulse seen", done_c, 1);
    if (tot == 0) begin
      chk(busy_n == 0, "R10 busy stays low", busy_n, 0);
      chk(done_c == 1, "R10 done next cycle", done_c, 1);
      chk(rises == 0, "R10 no slow clock", rises, 0);
    end else begin
      chk(nxt == tot, "R2 bit count", nxt, tot);
      chk(extra == 0, "R8 spurious ready", extra, 0);
      chk(rises == tot, "R11 slow clock edges", rises, tot);
      chk(busy_n == acc[tot-1] + 8, "R9 busy length", busy_n, acc[tot-1] + 8);
      chk(done_c == acc[tot-1] + 9, "R9 done timing", done_c, acc[tot-1] + 9);
      if (!stall) chk(hi_n == 3 * tot, "R11 slow clock duty", hi_n, 3 * tot);
      for (int k = 0; k < tot; k++) begin
        if (!stall) chk(acc[k] == 1 + 8 * k, "R1 cadence", acc[k], 1 + 8 * k);
        chk(r_dout[acc[k]+1] == wb[k], "R1 bit first cycle", int'(r_dout[acc[k]+1]), int'(wb[k]));
        chk(r_dout[acc[k]+8] == wb[k], "R1 bit eighth cycle", int'(r_dout[acc[k]+8]), int'(wb[k]));
        chk(r_load[acc[k]+1] == (k >= c * 8), "R3 load level", int'(r_load[acc[k]+1]), int'(k >= c * 8));
        chk(rs_val[k] == wb[k], "R2 order at slow edge", int'(rs_val[k]), int'(wb[k]));
        chk(rs_ld[k] == (k >= c * 8), "R3 load at slow edge", int'(rs_ld[k]), int'(k >= c * 8));
      end
    end
  endtask

  task automatic run_read(input int d, input logic [15:0] mask, input bit poke);
    int   busy_n = 0;
    int   rises  = 0;
    int   first  = -1;
    int   rdy_n  = 0;
    int   done_c = -1;
    logic prev   = 1'b0;
    logic [4:0] hdr = 5'b11101;
    @(negedge clk);
    mode = 1'b1; ctrl_cnt = 3'd5; data_cnt = 13'(d); fe_enable = mask; start = 1'b1;
    fe_din = 16'h0;
    for (int cy = 1; cy < 1500; cy++) begin
      @(negedge clk);
      start = poke && (cy == 9);
      mode  = !(poke && (cy == 9));
      if (busy) busy_n++;
      if (wr_ready) rdy_n++;
      if (fe_sclk && !prev) begin
        if (first < 0) first = cy;
        rises++;
      end
      prev = fe_sclk;
      r_l0[cy] = rb_lane0; r_l1[cy] = rb_lane1; r_rbv[cy] = rb_valid;
      if (done) begin
        done_c = cy;
        break;
      end
      step_lfsr();
      fe_din = lfsr;
      r_din[cy] = lfsr;
    end
    start = 1'b0; mode = 1'b0;
    chk(done_c == 6 + 8 * d, "R9 readback done timing", done_c, 6 + 8 * d);
    chk(busy_n == 5 + 8 * d, "R9 readback busy length", busy_n, 5 + 8 * d);
    chk(rises == d, "R11 readback slow edges", rises, d);
    chk(rdy_n == 0, "R8 ready low in readback", rdy_n, 0);
    if (d > 0) chk(first == 6, "R5 first sampling edge", first, 6);
    if (done_c > 0) begin
      chk(!r_rbv[done_c] && !r_l0[done_c] && !r_l1[done_c], "R7 quiet after end",
          int'(r_rbv[done_c]), 0);
      for (int cy = 1; cy < done_c; cy++) begin
        logic exp_b;
        if (cy <= 5) exp_b = hdr[5 - cy];
        else         exp_b = |(r_din[8 * ((cy - 6) / 8) + 5] & mask);
        chk(r_rbv[cy], "R7 valid during readback", int'(r_rbv[cy]), 1);
        chk(r_l0[cy] == r_l1[cy], "R7 lanes equal", int'(r_l1[cy]), int'(r_l0[cy]));
        if (cy <= 5)
          chk(r_l0[cy] == exp_b, "R4 header bit", int'(r_l0[cy]), int'(exp_b));
        else if (mask == 16'h0)
          chk(r_l0[cy] == 1'b0, "R6 zero mask", int'(r_l0[cy]), 0);
        else
          chk(r_l0[cy] == exp_b, "R5 R6 masked OR data", int'(r_l0[cy]), int'(exp_b));
      end
    end
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; mode = 1'b0; ctrl_cnt = '0; data_cnt = '0;
    fe_enable = '0; fe_din = '0; wr_valid = 1'b0; wr_bit = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done, "R9 reset idle", int'(busy), 0);
    chk(!wr_ready && !fe_sclk, "R11 reset clock low", int'(fe_sclk), 0);
    chk(!fe_dout && !fe_load, "R3 reset write pins", int'(fe_dout), 0);
    chk(!rb_valid && !rb_lane0 && !rb_lane1, "R7 reset lanes", int'(rb_lane0), 0);

    for (int c = 0; c < 8; c++) begin
      run_write(c, 0, 1'b0);
      run_write(c, 1, 1'b0);
      run_write(c, 9, 1'b0);
    end
    run_write(1, 4, 1'b1);
    run_write(3, 11, 1'b1);
    run_write(0, 7, 1'b1);
    run_write(2, 0, 1'b1);

    for (int d = 0; d < 11; d++) begin
      run_read(d, 16'h0001, 1'b0);
      run_read(d, 16'h8000, 1'b0);
      run_read(d, 16'hA5A5, 1'b0);
      run_read(d, 16'h0000, 1'b0);
      run_read(d, 16'hFFFF, 1'b0);
    end
    run_read(4, 16'h0F0F, 1'b1);
    run_read(2, 16'h3000, 1'b1);

    run_write(1, 3, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule